// File: doc/BRIEF.md
# Backplane System and Local Reset Controller

This block combines the reset requests of a board into two reset outputs. The global output pulls the shared backplane system reset line low. It acts only while the board holds the system-controller role. Each global request produces a pulse of at least a configurable minimum width, 200 ms by default. The local output resets every device on the board. It is enabled in every role. It also answers to a system reset that arrives from the backplane.

The requesters are a debounced pushbutton, the power-on reset, a watchdog expiry pulse and an incoming backplane reset. Software adds two control bits through a plain write strobe. One bit fires a single global pulse and clears itself. The other is a level that holds the board in local reset until software clears it, so a faulty board can be kept off the system. External requests pass through a synchronizer. When the board drives the backplane line, it ignores its own pulse coming back on the incoming line. That echo cannot restart the local reset.

Top module: `bkpl_reset_ctrl`

## Requirements
- R1: `sysrst_drive_n` stays high while `sys_ctrl` is 0. A software global request written while `sys_ctrl` is 0 is discarded and does not fire when `sys_ctrl` later becomes 1.
- R2: With `sys_ctrl` = 1, the pushbutton (`btn_n` low), a watchdog pulse (`wdog_expire` high) or a software global request each drive `sysrst_drive_n` low.
- R3: The global output stays low for exactly GLB_CYC cycles after the last cycle in which a request was seen, where GLB_CYC = CLK_HZ·GLB_MIN_US/10^6. A new request during the pulse restarts the count.
- R4: `local_rst_n` answers its requests whatever the value of `sys_ctrl`.
- R5: The local output is driven low by the pushbutton, a watchdog pulse, a low `bus_sysrst_in_n`, or the hold bit. It stays low for exactly LCL_CYC cycles after the last request, where LCL_CYC = CLK_HZ·LCL_MIN_US/10^6.
- R6: Writing `sw_wdata` bit 0 = 1 with `sw_wr` = 1 sets the global request bit. The bit clears in the cycle the global pulse starts, so one write gives exactly one pulse of GLB_CYC cycles, starting one cycle after the write.
- R7: `sw_wdata` bit 1 is the hold bit, and every write loads it. While it is 1, `local_rst_n` stays low for any length of time. After a write that clears it, `local_rst_n` rises LCL_CYC cycles after that write edge. The hold bit has no effect on the global output.
- R8: An external request that is sampled before a rising edge e0 drives its output low after edge e0+SYNC_STAGES, and not sooner.
- R9: While the board drives the global line, and for SYNC_STAGES cycles after it stops, a low `bus_sysrst_in_n` is ignored by the local path. At other times an incoming backplane reset is honoured in the controller role as well.
- R10: While `por_n` is low, both outputs are low (the global output only if `sys_ctrl` = 1). After `por_n` is released, each output rises on the GLB_CYC-th or LCL_CYC-th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| sys_ctrl | input | 1 | Board holds the backplane system-controller role |
| btn_n | input | 1 | Debounced reset pushbutton, active low |
| wdog_expire | input | 1 | Watchdog timeout, active high |
| bus_sysrst_in_n | input | 1 | Backplane system reset as received, active low |
| sw_wr | input | 1 | Control write strobe |
| sw_wdata | input | 2 | Control data: bit 0 global request, bit 1 local hold |
| sysrst_drive_n | output | 1 | Pull-down request for the backplane system reset line, active low |
| local_rst_n | output | 1 | Board reset, active low |

## Verification
An external request passes through SYNC_STAGES synchronizer flops and one counter load. With two stages, its output falls after the third rising edge following the sampling edge. A software request goes through one register, so its output falls after the second edge. The hold release is counted from the edge that clears the bit. The bench drives inputs and samples outputs only on falling edges. It checks that the output is still high at each falling edge before the one where the change is due. It then counts consecutive low samples from the first due sample and compares that count with GLB_CYC, LCL_CYC or their sum with the restart offset.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Control word written by software
  typedef struct packed {
    logic hold;   // bit 1: keep the board in local reset
    logic go;     // bit 0: fire one global reset pulse
  } rstc_ctrl_t;

  // Clock cycles in a time span given in microseconds, never below one
  function automatic int unsigned rstc_cycles(input longint unsigned clk_hz,
                                              input longint unsigned span_us);
    longint unsigned c;
    c = (clk_hz * span_us) / 64'd1000000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  // Bits needed to hold a count from 0 to n
  function automatic int unsigned rstc_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active,
  output logic load
);

  localparam int unsigned CW = rstc_pkg::rstc_width(CYC);
  localparam logic [CW-1:0] FULL = CW'(CYC);

  logic [CW-1:0] cnt;

  assign load = trig;

  // Reset loads the full count, so power-on release is itself a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= FULL;
    else if (trig)       cnt <= FULL;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

endmodule

// File: rtl/rstc_ctrl_reg.sv
module rstc_ctrl_reg (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  rstc_pkg::rstc_ctrl_t wr_data,
  input  logic                 sys_ctrl,
  input  logic                 go_taken,
  output logic                 go_pend,
  output logic                 hold_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    go_pend <= 1'b0;
    else if (!sys_ctrl)            go_pend <= 1'b0;
    else if (wr_en && wr_data.go)  go_pend <= 1'b1;
    else if (go_taken)             go_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= 1'b0;
    else if (wr_en) hold_q <= wr_data.hold;
  end

endmodule

// File: rtl/bkpl_reset_ctrl.sv
module bkpl_reset_ctrl #(
  parameter int unsigned CLK_HZ      = 125000000,
  parameter int unsigned GLB_MIN_US  = 200000,
  parameter int unsigned LCL_MIN_US  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_ctrl,
  input  logic       btn_n,
  input  logic       wdog_expire,
  input  logic       bus_sysrst_in_n,
  input  logic       sw_wr,
  input  logic [1:0] sw_wdata,
  output logic       sysrst_drive_n,
  output logic       local_rst_n
);

  import rstc_pkg::*;

  localparam int unsigned GLB_CYC = rstc_cycles(CLK_HZ, GLB_MIN_US);
  localparam int unsigned LCL_CYC = rstc_cycles(CLK_HZ, LCL_MIN_US);
  localparam int SRC_N = 3;

  // Named internal events, visible to the checker
  logic [SRC_N-1:0] src_raw, src_sync;
  logic btn_act, wdog_act, bus_act;
  logic go_pend, hold_q;
  logic glb_trig, glb_load, glb_active, glb_drive;
  logic loc_trig, loc_load, loc_active;
  logic echo_mask, ext_trig;
  logic [SYNC_STAGES-1:0] drive_hist;

  assign src_raw = {~bus_sysrst_in_n, wdog_expire, ~btn_n};

  rstc_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d(src_raw), .q(src_sync)
  );

  assign btn_act  = src_sync[0];
  assign wdog_act = src_sync[1];
  assign bus_act  = src_sync[2];

  rstc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(por_n), .wr_en(sw_wr), .wr_data(rstc_ctrl_t'(sw_wdata)),
    .sys_ctrl(sys_ctrl), .go_taken(glb_load), .go_pend(go_pend), .hold_q(hold_q)
  );

  // Global path: only the system controller may request it
  assign glb_trig = sys_ctrl & (btn_act | wdog_act | go_pend);

  rstc_stretch #(.CYC(GLB_CYC)) u_glb (
    .clk(clk), .rst_n(por_n), .trig(glb_trig), .active(glb_active), .load(glb_load)
  );

  assign glb_drive = sys_ctrl & glb_active;

  // History of own drive covers the synchronizer delay of the echo
  generate
    if (SYNC_STAGES == 1) begin : g_hist1
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) drive_hist <= '0;
        else        drive_hist <= glb_drive;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) drive_hist <= '0;
        else        drive_hist <= {drive_hist[SYNC_STAGES-2:0], glb_drive};
      end
    end
  endgenerate

  assign echo_mask = glb_drive | (|drive_hist);
  assign ext_trig  = bus_act & ~echo_mask;

  // Local path: active in every role
  assign loc_trig = btn_act | wdog_act | ext_trig | hold_q;

  rstc_stretch #(.CYC(LCL_CYC)) u_loc (
    .clk(clk), .rst_n(por_n), .trig(loc_trig), .active(loc_active), .load(loc_load)
  );

  assign sysrst_drive_n = ~glb_drive;
  assign local_rst_n    = ~loc_active;

endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
  parameter int unsigned GLB_CYC = 16,
  parameter int unsigned LCL_CYC = 16
) (
  input logic clk,
  input logic por_n,
  input logic sys_ctrl,
  input logic sysrst_drive_n,
  input logic local_rst_n,
  input logic go_pend,
  input logic hold_q,
  input logic loc_trig
);

  int unsigned g_low, l_low;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      g_low <= 0;
      l_low <= 0;
    end else begin
      g_low <= sysrst_drive_n ? 0 : ((g_low < GLB_CYC) ? g_low + 1 : g_low);
      l_low <= local_rst_n    ? 0 : ((l_low < LCL_CYC) ? l_low + 1 : l_low);
    end
  end

  p_gate_r1: assert property (@(posedge clk) disable iff (!por_n)
    !sys_ctrl |-> sysrst_drive_n);

  p_glb_width_r3: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(sysrst_drive_n) && $past(sys_ctrl) && sys_ctrl) |-> (g_low >= GLB_CYC));

  p_loc_width_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(local_rst_n) |-> (l_low >= LCL_CYC));

  p_go_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
    go_pend |=> !go_pend);

  p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    hold_q |=> !local_rst_n);

  p_loc_any_role_r4: assert property (@(posedge clk) disable iff (!por_n)
    loc_trig |=> !local_rst_n);

endmodule

bind bkpl_reset_ctrl rstc_chk #(.GLB_CYC(GLB_CYC), .LCL_CYC(LCL_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .sys_ctrl(sys_ctrl),
  .sysrst_drive_n(sysrst_drive_n), .local_rst_n(local_rst_n),
  .go_pend(go_pend), .hold_q(hold_q), .loc_trig(loc_trig)
);

// File: tb/bkpl_reset_ctrl_test.sv
`timescale 1ns/1ps
module bkpl_reset_ctrl_test;

  localparam int GLB = 200;  // 1 MHz x 200 us
  localparam int LCL = 40;   // 1 MHz x 40 us

  logic clk = 0, por_n = 0, sys_ctrl = 1, btn_n = 1, wdog_expire = 0;
  logic ext_n = 1, loop = 0, sw_wr = 0;
  logic [1:0] sw_wdata = 0;
  logic bus_sysrst_in_n, sysrst_drive_n, local_rst_n;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign bus_sysrst_in_n = ext_n & (loop ? sysrst_drive_n : 1'b1);

  bkpl_reset_ctrl #(.CLK_HZ(1000000), .GLB_MIN_US(200), .LCL_MIN_US(40),
                    .SYNC_STAGES(2)) uut (
    .clk(clk), .por_n(por_n), .sys_ctrl(sys_ctrl), .btn_n(btn_n),
    .wdog_expire(wdog_expire), .bus_sysrst_in_n(bus_sysrst_in_n),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sysrst_drive_n(sysrst_drive_n), .local_rst_n(local_rst_n));

  task automatic check(input string req, input int got, input int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    return (sel == 0) ? sysrst_drive_n : local_rst_n;
  endfunction

  // Consecutive low samples from the current falling edge on
  task automatic count_low(input int sel, input int lim, output int n);
    n = 0;
    while (n < lim && sig(sel) == 1'b0) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Low samples seen over a fixed number of falling edges
  task automatic lows_over(input int sel, input int span, output int n);
    n = 0;
    for (int i = 0; i < span; i++) begin
      if (sig(sel) == 1'b0) n++;
      @(negedge clk);
    end
  endtask

  task automatic sw_write(input logic hold, input logic go);
    sw_wdata = {hold, go};
    sw_wr = 1;
    @(negedge clk);
    sw_wr = 0;
    sw_wdata = 0;
  endtask

  task automatic settle();
    repeat (GLB + 20) @(negedge clk);
  endtask

  task automatic t_por();
    int ng, nl;
    sys_ctrl = 1;
    repeat (3) @(negedge clk);
    check("R10 global low in reset", sysrst_drive_n, 0);
    check("R10 local low in reset", local_rst_n, 0);
    por_n = 1;
    @(negedge clk);
    fork
      count_low(0, GLB + 10, ng);
      count_low(1, LCL + 10, nl);
    join
    check("R10 global release edge", ng, GLB - 1);
    check("R10 local release edge", nl, LCL - 1);
    settle();
  endtask

  task automatic t_button();
    int ng, nl;
    sys_ctrl = 1;
    btn_n = 0;
    @(negedge clk);
    btn_n = 1;
    check("R8 global not early 1", sysrst_drive_n, 1);
    @(negedge clk);
    check("R8 local not early 2", local_rst_n, 1);
    @(negedge clk);
    check("R8 global due", sysrst_drive_n, 0);
    fork
      count_low(0, GLB + 10, ng);
      count_low(1, LCL + 10, nl);
    join
    check("R2 R3 button global width", ng, GLB);
    check("R5 button local width", nl, LCL);
    settle();
  endtask

  task automatic t_wdog_restart();
    int ng;
    sys_ctrl = 1;
    wdog_expire = 1;
    @(negedge clk);
    wdog_expire = 0;
    @(negedge clk);
    @(negedge clk);
    fork
      count_low(0, GLB + 200, ng);
      begin
        repeat (97) @(negedge clk);
        wdog_expire = 1;
        @(negedge clk);
        wdog_expire = 0;
      end
    join
    check("R3 restart width", ng, GLB + 100);
    settle();
  endtask

  task automatic t_sw_go_echo();
    int ng, nl;
    sys_ctrl = 1;
    loop = 1;
    sw_write(0, 1);
    check("R6 not before load", sysrst_drive_n, 1);
    @(negedge clk);
    fork
      count_low(0, GLB + 10, ng);
      lows_over(1, GLB + 10, nl);
    join
    check("R6 single sw pulse width", ng, GLB);
    check("R9 echo ignored by local", nl, 0);
    lows_over(0, GLB, ng);
    check("R6 no second pulse", ng, 0);
    loop = 0;
    ext_n = 0;
    @(negedge clk);
    ext_n = 1;
    @(negedge clk);
    @(negedge clk);
    count_low(1, LCL + 10, nl);
    check("R9 real bus reset honoured as controller", nl, LCL);
    settle();
  endtask

  task automatic t_not_ctrl();
    int ng, nl;
    sys_ctrl = 0;
    @(negedge clk);
    btn_n = 0;
    @(negedge clk);
    btn_n = 1;
    @(negedge clk);
    @(negedge clk);
    fork
      lows_over(0, LCL + 10, ng);
      count_low(1, LCL + 10, nl);
    join
    check("R1 global idle off-role", ng, 0);
    check("R4 local off-role", nl, LCL);
    ext_n = 0;
    @(negedge clk);
    ext_n = 1;
    @(negedge clk);
    @(negedge clk);
    count_low(1, LCL + 10, nl);
    check("R5 bus reset local width", nl, LCL);
    sw_write(0, 1);
    @(negedge clk);
    sys_ctrl = 1;
    lows_over(0, 20, ng);
    check("R1 discarded sw request", ng, 0);
    settle();
  endtask

  task automatic t_hold();
    int ng, nl;
    sys_ctrl = 1;
    sw_write(1, 0);
    @(negedge clk);
    fork
      lows_over(1, 300, nl);
      lows_over(0, 300, ng);
    join
    check("R7 held low", nl, 300);
    check("R7 hold leaves global", ng, 0);
    sw_write(0, 0);
    count_low(1, LCL + 10, nl);
    check("R7 release width", nl, LCL);
    settle();
  endtask

  initial begin
    t_por();
    t_button();
    t_wdog_restart();
    t_sw_go_echo();
    t_not_ctrl();
    t_hold();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule